// File: doc/BRIEF.md
# SPI Slave Serial Front End

This block is the serial edge of a chip that an external SPI master controls. It runs entirely in the system clock domain. The serial clock, the active-low select and the master-out data pass through flop synchronizers. Edge detection on those signals then decides when a bit is captured and when the next bit is driven. The clock polarity and the clock phase are chosen by parameters before synthesis, so one design covers all four SPI modes. Bytes are exchanged full duplex with the most significant bit first in both directions.

Downstream logic receives each completed byte with a one-cycle valid strobe. It supplies the next outgoing byte through a valid/ready handshake into a one-byte stage. The receive stream has no back-pressure: the serial master sets the pace, so a consumer must take every strobed byte. On the transmit side, `tx_ready` is high while the stage is empty. A byte offered with `tx_valid` is accepted on a clock edge where both are high. The byte stays staged until the next byte on the wire begins.

The serial output leaves as a value with a separate enable, so several slaves can share one data-out wire. The pad's readback comes back in as an input. Frame boundaries are reported as one-cycle pulses. A rise of select aborts whatever frame is in flight.

Top module: `serial_slave_port`

## Requirements
- R1: Data moves most significant bit first in both directions at the same time. The first eight sampled `mosi_in` bits of a byte appear on `rx_data` with the first bit in bit 7. Bit 7 of the byte driven out is presented first.
- R2: With CPOL=0 the serial clock idles low, and with CPOL=1 it idles high. The leading edge is the first edge away from the idle level. With CPHA=0, input is sampled on leading edges and output changes on trailing edges. With CPHA=1, output changes on leading edges and input is sampled on trailing edges.
- R3: `rx_valid` is high for exactly one system clock cycle per completed byte, a few cycles after that byte's eighth sampling edge. `rx_data` is valid while `rx_valid` is high.
- R4: Transmit handshake: `tx_ready` is high exactly when the one-byte stage is empty. A byte is taken on a clock edge where `tx_valid` and `tx_ready` are both high. The stage is emptied only when a byte begins on the wire.
- R5: If the stage is empty when a byte begins on the wire, the slave sends 0x00 for that byte.
- R6: `miso_oe` is high only while the synchronized select is low. While select is high, the output is released. `miso_out` changes within four system clocks of the serial clock edge that launches a bit, so transmit needs a serial half-period of at least four system clocks.
- R7: `frame_start` pulses for one cycle after each fall of select, and `frame_end` pulses for one cycle after each rise.
- R8: A rise of select in the middle of a byte discards the partial byte with no `rx_valid`. The next frame starts again at bit 7.
- R9: Serial clock edges while select is high have no effect: no byte is received and nothing is driven.
- R10: Reception is correct with the serial clock at one quarter of the system clock, that is, a half-period of two system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_in | input | 1 | Serial clock from the master (asynchronous) |
| cs_n_in | input | 1 | Active-low slave select (asynchronous) |
| mosi_in | input | 1 | Serial data from the master (asynchronous) |
| miso_in | input | 1 | Readback of the shared data-out pad |
| miso_out | output | 1 | Value driven onto the data-out pad |
| miso_oe | output | 1 | Enable for the data-out pad driver, high when driving |
| rx_data | output | WORD_W | Last received byte |
| rx_valid | output | 1 | One-cycle strobe marking a new `rx_data` |
| tx_data | input | WORD_W | Next byte to transmit |
| tx_valid | input | 1 | `tx_data` is offered |
| tx_ready | output | 1 | Transmit stage empty, offer will be taken |
| frame_start | output | 1 | One-cycle pulse after select falls |
| frame_end | output | 1 | One-cycle pulse after select rises |

## Verification
The hardest case to reach from the ports is a frame cut off part way through a byte. The receive counter and the transmit byte state must both be reset, and the partly consumed transmit byte must not shift the next frame's alignment. The bench drives a master model that raises select after eleven bits. It then runs a full frame on the same slave and compares both directions byte by byte. Serial clock toggling while deselected, an empty transmit stage and quarter-rate reception are reached with directed frames. Random frames vary the half-period, length and data across all four modes.

// File: rtl/sspi_pkg.sv
`timescale 1ns/1ps
package sspi_pkg;
  // Serial clock events in the system clock domain, already gated by select.
  typedef struct packed {
    logic sample;  // capture mosi
    logic launch;  // present the next miso bit
  } sclk_ev_t;
endpackage

// File: rtl/sspi_sync.sv
`timescale 1ns/1ps
module sspi_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] INIT = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= {STAGES{INIT}};
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/sspi_edge.sv
`timescale 1ns/1ps
module sspi_edge
  import sspi_pkg::*;
#(
  parameter bit CPOL = 1'b0,
  parameter bit CPHA = 1'b0
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     sclk_s,
  input  logic     cs_n_s,
  output sclk_ev_t ev,
  output logic     active,
  output logic     frame_start,
  output logic     frame_end
);
  logic sclk_d, cs_d;
  logic lead, trail;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d      <= CPOL;
      cs_d        <= 1'b1;
      frame_start <= 1'b0;
      frame_end   <= 1'b0;
    end else begin
      sclk_d      <= sclk_s;
      cs_d        <= cs_n_s;
      frame_start <= cs_d & ~cs_n_s;
      frame_end   <= ~cs_d & cs_n_s;
    end
  end

  // leading edge leaves the idle level, trailing edge returns to it
  assign lead   = (sclk_d == CPOL) && (sclk_s != CPOL);
  assign trail  = (sclk_d != CPOL) && (sclk_s == CPOL);
  assign active = ~cs_n_s;

  always_comb begin
    ev.sample = active && (CPHA ? trail : lead);
    ev.launch = active && (CPHA ? lead : trail);
  end

  // R7
  frame_start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !frame_start);
  // R7
  frame_end_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> !frame_end);
endmodule

// File: rtl/sspi_rx.sv
`timescale 1ns/1ps
module sspi_rx
  import sspi_pkg::*;
#(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  sclk_ev_t          ev,
  input  logic              mosi_s,
  output logic [WORD_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              byte_done
);
  localparam int CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic [CNT_W-1:0]  bit_cnt;
  logic [WORD_W-2:0] acc;

  assign byte_done = ev.sample && (bit_cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt  <= '0;
      acc      <= '0;
      rx_data  <= '0;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= byte_done;
      if (!active) begin
        bit_cnt <= '0;
      end else if (ev.sample) begin
        acc     <= {acc[WORD_W-3:0], mosi_s};
        bit_cnt <= byte_done ? '0 : bit_cnt + 1'b1;
        if (byte_done) rx_data <= {acc, mosi_s};
      end
    end
  end

  // R3
  rx_valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  // R9
  rx_quiet_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> !rx_valid);
endmodule

// File: rtl/sspi_tx.sv
`timescale 1ns/1ps
module sspi_tx
  import sspi_pkg::*;
#(
  parameter int WORD_W = 8,
  parameter bit CPHA   = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  sclk_ev_t          ev,
  input  logic              byte_done,
  input  logic [WORD_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic              miso_bit
);
  logic [WORD_W-1:0] stage_q, shreg;
  logic              stage_full, open;
  logic              start, push;

  // a byte begins on its first sampling edge (CPHA=0) or first launching edge (CPHA=1)
  assign start    = active && !open && (CPHA ? ev.launch : ev.sample);
  assign push     = tx_valid && !stage_full;
  assign tx_ready = !stage_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= '0;
      stage_full <= 1'b0;
      shreg      <= '0;
      open       <= 1'b0;
    end else begin
      stage_full <= push | (stage_full & ~start);
      if (push) stage_q <= tx_data;
      if (!active) begin
        open <= 1'b0;
      end else if (start) begin
        shreg <= stage_full ? stage_q : '0;
        open  <= 1'b1;
      end else if (open) begin
        if (ev.launch) shreg <= {shreg[WORD_W-2:0], 1'b0};
        if (byte_done) open <= 1'b0;
      end
    end
  end

  // between bytes the pin previews the MSB the next byte will carry
  assign miso_bit = open ? shreg[WORD_W-1] : (stage_full & stage_q[WORD_W-1]);

  // R4
  tx_accept_fills_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !tx_ready);
endmodule

// File: rtl/serial_slave_port.sv
`timescale 1ns/1ps
module serial_slave_port
  import sspi_pkg::*;
#(
  parameter bit CPOL        = 1'b0,
  parameter bit CPHA        = 1'b0,
  parameter int WORD_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_in,
  input  logic              cs_n_in,
  input  logic              mosi_in,
  input  logic              miso_in,
  output logic              miso_out,
  output logic              miso_oe,
  output logic [WORD_W-1:0] rx_data,
  output logic              rx_valid,
  input  logic [WORD_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic              frame_start,
  output logic              frame_end
);
  localparam int PIN_N = 3;
  localparam logic [PIN_N-1:0] PIN_INIT = {CPOL, 1'b1, 1'b0};

  logic [PIN_N-1:0] pins_s;
  sclk_ev_t         ev;
  logic             active, byte_done;

  sspi_sync #(.WIDTH(PIN_N), .STAGES(SYNC_STAGES), .INIT(PIN_INIT)) u_sync (
    .clk (clk), .rst_n (rst_n),
    .d   ({sclk_in, cs_n_in, mosi_in}),
    .q   (pins_s)
  );

  sspi_edge #(.CPOL(CPOL), .CPHA(CPHA)) u_edge (
    .clk (clk), .rst_n (rst_n),
    .sclk_s (pins_s[2]), .cs_n_s (pins_s[1]),
    .ev (ev), .active (active),
    .frame_start (frame_start), .frame_end (frame_end)
  );

  sspi_rx #(.WORD_W(WORD_W)) u_rx (
    .clk (clk), .rst_n (rst_n),
    .active (active), .ev (ev), .mosi_s (pins_s[0]),
    .rx_data (rx_data), .rx_valid (rx_valid), .byte_done (byte_done)
  );

  sspi_tx #(.WORD_W(WORD_W), .CPHA(CPHA)) u_tx (
    .clk (clk), .rst_n (rst_n),
    .active (active), .ev (ev), .byte_done (byte_done),
    .tx_data (tx_data), .tx_valid (tx_valid), .tx_ready (tx_ready),
    .miso_bit (miso_out)
  );

  assign miso_oe = active;

  // checker: run length of select held high at the pin
  logic [7:0] hi_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hi_run <= '0;
    else if (!cs_n_in) hi_run <= '0;
    else if (hi_run != 8'hFF) hi_run <= hi_run + 1'b1;
  end

  // R6
  oe_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_run >= 8'(SYNC_STAGES)) |-> !miso_oe);
  // R6
  miso_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    miso_oe |-> (miso_in == miso_out));
endmodule

// File: tb/serial_slave_port_test.sv
`timescale 1ns/1ps
module serial_slave_port_test;
  localparam int NM = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz
  logic rst_n;

  logic [NM-1:0] sclk, cs_n, miso_out, miso_oe, miso_pad;
  logic [NM-1:0] rx_valid, tx_valid, tx_ready, f_start, f_end;
  logic          mosi;
  logic [7:0]    rx_data [NM];
  logic [7:0]    tx_data [NM];

  for (genvar m = 0; m < NM; m++) begin : g_mode
    assign miso_pad[m] = miso_oe[m] ? miso_out[m] : 1'b1;  // pull-up when released
    serial_slave_port #(.CPOL(bit'((m / 2) % 2)), .CPHA(bit'(m % 2))) uut (
      .clk (clk), .rst_n (rst_n),
      .sclk_in (sclk[m]), .cs_n_in (cs_n[m]), .mosi_in (mosi),
      .miso_in (miso_pad[m]), .miso_out (miso_out[m]), .miso_oe (miso_oe[m]),
      .rx_data (rx_data[m]), .rx_valid (rx_valid[m]),
      .tx_data (tx_data[m]), .tx_valid (tx_valid[m]), .tx_ready (tx_ready[m]),
      .frame_start (f_start[m]), .frame_end (f_end[m])
    );
  end

  int tests = 0;
  int fails = 0;

  // transmit feeder: bench list per mode, consumed through valid/ready
  logic [7:0] tx_list [NM][256];
  int tx_len [NM] = '{default: 0};
  int tx_idx [NM] = '{default: 0};
  bit pend   [NM] = '{default: 1'b0};

  always @(negedge clk) begin
    for (int m = 0; m < NM; m++) begin
      if (pend[m]) tx_idx[m]++;
      if (tx_idx[m] < tx_len[m]) begin
        tx_valid[m] = 1'b1;
        tx_data[m]  = tx_list[m][tx_idx[m]];
      end else begin
        tx_valid[m] = 1'b0;
        tx_data[m]  = 8'h00;
      end
      pend[m] = tx_valid[m] && tx_ready[m];
    end
  end

  // output monitor
  logic [7:0] rx_log [NM][512];
  int rx_cnt [NM] = '{default: 0};
  int fs_cnt [NM] = '{default: 0};
  int fe_cnt [NM] = '{default: 0};
  int pulse_err [NM] = '{default: 0};
  bit rv_p [NM] = '{default: 1'b0};
  bit fs_p [NM] = '{default: 1'b0};
  bit fe_p [NM] = '{default: 1'b0};

  always @(negedge clk) begin
    for (int m = 0; m < NM; m++) begin
      if ((rx_valid[m] && rv_p[m]) || (f_start[m] && fs_p[m]) || (f_end[m] && fe_p[m]))
        pulse_err[m]++;
      if (rx_valid[m]) begin
        rx_log[m][rx_cnt[m] % 512] = rx_data[m];
        rx_cnt[m]++;
      end
      if (f_start[m]) fs_cnt[m]++;
      if (f_end[m])   fe_cnt[m]++;
      rv_p[m] = rx_valid[m];
      fs_p[m] = f_start[m];
      fe_p[m] = f_end[m];
    end
  end

  int frames [NM] = '{default: 0};

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic cpol_of(input int m);
    return logic'((m / 2) % 2);
  endfunction

  function automatic bit cpha_of(input int m);
    return bit'(m % 2);
  endfunction

  // expected byte on miso: the staged byte, or zero when nothing was staged
  function automatic logic [7:0] exp_tx(input bit supplied, input logic [7:0] b);
    return supplied ? b : 8'h00;
  endfunction

  // master model: cut < 0 runs all bits of nb bytes
  task automatic frame(input int m, input int nb, input int half, input int cut,
                       input logic [7:0] mo [4], output logic [7:0] mi [4], output int oe_bad);
    logic cp;
    int   total;
    cp     = cpol_of(m);
    total  = (cut >= 0) ? cut : nb * 8;
    oe_bad = 0;
    for (int b = 0; b < 4; b++) mi[b] = 8'h00;
    tick(1);
    cs_n[m] = 1'b0;
    tick(half + 2);
    for (int k = 0; k < total; k++) begin
      int b, i;
      b = k / 8;
      i = 7 - (k % 8);
      if (!cpha_of(m)) begin
        mosi = mo[b][i];
        tick(half);
        sclk[m] = ~cp;
        mi[b][i] = miso_pad[m];
        if (!miso_oe[m] || ((miso_oe & ~(NM'(1) << m)) != '0)) oe_bad++;
        tick(half);
        sclk[m] = cp;
      end else begin
        sclk[m] = ~cp;
        mosi = mo[b][i];
        tick(half);
        sclk[m] = cp;
        mi[b][i] = miso_pad[m];
        if (!miso_oe[m] || ((miso_oe & ~(NM'(1) << m)) != '0)) oe_bad++;
        tick(half);
      end
    end
    tick(half);
    cs_n[m] = 1'b1;
    tick(8);
    frames[m]++;
  endtask

  task automatic run_check(input int m, input int nb, input int half,
                           input bit supply, input bit chk_tx, input int pre_idle);
    logic [7:0] mo [4], mi [4], ex [4];
    int base, oe_bad;
    for (int b = 0; b < 4; b++) begin
      mo[b] = 8'($urandom);
      ex[b] = 8'($urandom);
    end
    if (supply) begin
      for (int b = 0; b < nb; b++) begin
        tx_list[m][tx_len[m]] = ex[b];
        tx_len[m]++;
      end
      tick(4);
      chk(tx_ready[m] == 1'b0, "R4 staged byte holds ready low", int'(tx_ready[m]), 0);
    end
    tick(pre_idle);
    base = rx_cnt[m];
    frame(m, nb, half, -1, mo, mi, oe_bad);
    chk(rx_cnt[m] == base + nb, "R3 one strobe per byte", rx_cnt[m] - base, nb);
    for (int b = 0; b < nb; b++) begin
      chk(rx_log[m][(base + b) % 512] == mo[b],
          (half == 2) ? "R10 quarter-rate rx byte" : "R1 R2 rx byte",
          int'(rx_log[m][(base + b) % 512]), int'(mo[b]));
      if (chk_tx)
        chk(mi[b] == exp_tx(supply, ex[b]), supply ? "R1 R2 tx byte" : "R5 empty stage sends zero",
            int'(mi[b]), int'(exp_tx(supply, ex[b])));
    end
    chk(oe_bad == 0, "R6 enable only on selected slave", oe_bad, 0);
  endtask

  task automatic abort_check(input int m);
    logic [7:0] mo [4], mi [4], ex [4];
    int base, oe_bad;
    for (int b = 0; b < 4; b++) begin
      mo[b] = 8'($urandom);
      ex[b] = 8'($urandom);
    end
    for (int b = 0; b < 2; b++) begin
      tx_list[m][tx_len[m]] = ex[b];
      tx_len[m]++;
    end
    tick(4);
    base = rx_cnt[m];
    frame(m, 2, 5, 11, mo, mi, oe_bad);
    chk(rx_cnt[m] == base + 1, "R8 partial byte dropped", rx_cnt[m] - base, 1);
    chk(rx_log[m][base % 512] == mo[0], "R8 whole byte before abort",
        int'(rx_log[m][base % 512]), int'(mo[0]));
    chk(mi[0] == ex[0], "R8 tx byte before abort", int'(mi[0]), int'(ex[0]));
    run_check(m, 2, 5, 1'b1, 1'b1, 0);  // R8 realignment after abort
  endtask

  task automatic idle_toggle(input int m);
    int base;
    base = rx_cnt[m];
    for (int k = 0; k < 18; k++) begin
      sclk[m] = ~sclk[m];
      mosi = 1'($urandom);
      tick(3);
    end
    chk(rx_cnt[m] == base, "R9 no byte while deselected", rx_cnt[m] - base, 0);
    chk(miso_oe[m] == 1'b0, "R9 R6 output released while deselected", int'(miso_oe[m]), 0);
    run_check(m, 1, 4, 1'b1, 1'b1, 0);
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    rst_n = 1'b0;
    mosi  = 1'b0;
    cs_n  = '1;
    for (int m = 0; m < NM; m++) sclk[m] = cpol_of(m);
    tick(5);
    rst_n = 1'b1;
    tick(4);

    // reset state
    chk(miso_oe == '0, "R6 reset released", int'(miso_oe), 0);
    chk(rx_valid == '0, "R3 reset no strobe", int'(rx_valid), 0);
    chk(tx_ready == '1, "R4 reset stage empty", int'(tx_ready), 'hF);
    chk((f_start | f_end) == '0, "R7 reset no pulses", int'(f_start | f_end), 0);

    for (int m = 0; m < NM; m++) begin
      run_check(m, 2, 4, 1'b1, 1'b1, 40);         // staged byte waits for the frame
      for (int r = 0; r < 6; r++)
        run_check(m, 1 + int'($urandom_range(3)), 4 + int'($urandom_range(3)), 1'b1, 1'b1, 0);
      run_check(m, 2, 5, 1'b0, 1'b1, 0);          // R5
      run_check(m, 3, 2, 1'b1, 1'b0, 0);          // R10
      abort_check(m);                              // R8
      idle_toggle(m);                              // R9
      chk(fs_cnt[m] == frames[m], "R7 start pulses", fs_cnt[m], frames[m]);
      chk(fe_cnt[m] == frames[m], "R7 end pulses", fe_cnt[m], frames[m]);
      chk(pulse_err[m] == 0, "R3 R7 single-cycle pulses", pulse_err[m], 0);
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule